// File: doc/BRIEF.md
# Clock Synthesizer Control and Status Unit

This unit is the software-facing controller of a system clock synthesizer. A single 16-bit register carries the frequency settings in its upper byte and the clock mode and status flags in its lower byte. The settings are driven straight to the synthesizer. The oscillator and the VCO sit outside the unit. They are seen here only through two inputs: one reports lock and one reports that the reference is present.

The unit also does five other jobs. It divides the system clock down to an E-bus clock. It holds the system in reset after power-up until the synthesizer first locks. On loss of the reference it either falls back to limp operation or raises system reset, as one control bit chooses. It opens a relock wait whenever a feedback-loop setting changes. During low-power stop it picks the internal clock source and gates the output clock.

Software reaches the register over a simple select/write bus. Every access is qualified by a supervisor-privilege input, and read data returns one cycle after the access.

Top module: `clk_ctl_unit`

## Requirements
- R1: After synchronous reset, a supervisor read returns 16'h3F00. This means VCO multiplier bit = 0, prescale bit = 0, loop modulus = 63, and every lower-byte bit = 0. bus_rdata is 0 while reset is held.
- R2: A supervisor write (bus_sel=1, bus_wr=1, bus_super=1) loads the writable fields in one clock: bit 15 VCO multiplier, bit 14 prescale, bits 13:8 loop modulus, bit 7 E-clock rate, bit 2 loss-action, bit 1 stop-source, bit 0 stop-output. Written values for bits 6:5 (always read 0), bit 4 (limp flag) and bit 3 (lock flag) are ignored.
- R3: A supervisor read (bus_sel=1, bus_wr=0, bus_super=1) places the register on bus_rdata at the next clock edge, using the bit layout of R2. When no supervisor read takes place, bus_rdata is 0.
- R4: A non-supervisor read returns 0, and a non-supervisor write leaves every field unchanged.
- R5: eclk is a registered square wave. With bit 7 = 0 it toggles every ECLK_FAST_DIV/2 cycles, giving system clock / 8. With bit 7 = 1 it toggles every ECLK_SLOW_DIV/2 cycles, giving system clock / 16. Its first rise comes ECLK_FAST_DIV/2 edges after reset is released.
- R6: The lock flag (bit 3) reads 0 until the first supervisor write. After that it reads vco_locked AND no relock wait pending.
- R7: A supervisor write that changes bit 15 or bits 13:8 starts a relock wait of RELOCK_CYCLES cycles, during which the lock flag reads 0. A write that changes only bit 14 starts no wait.
- R8: sys_rst_out is 1 from reset until the first clock edge that samples vco_locked=1. It drops at that edge.
- R9: With loss-action bit 2 = 0, ref_ok=0 sets limp (and bit 4) at the next edge without asserting sys_rst_out. Limp clears at the edge after ref_ok returns.
- R10: With bit 2 = 1, ref_ok=0 asserts sys_rst_out at the next edge, and limp stays 0.
- R11: While stop_req=1 with bit 1 = 0, int_clk_sel=0 (crystal) and vco_enable=0. With bit 1 = 1, or when not stopped, int_clk_sel=1 (VCO) and vco_enable=1. The update lags by one edge.
- R12: While stop_req=1, clkout_en equals bit 0. Outside stop, clkout_en=1. The update lags by one edge.
- R13: freq_w, freq_x and freq_y present bits 15, 14 and 13:8 of the register, and change in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| bus_sel | input | 1 | register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_super | input | 1 | accessing master is at supervisor level |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | read data, valid the cycle after a read |
| vco_locked | input | 1 | synthesizer reports lock |
| ref_ok | input | 1 | reference clock present |
| stop_req | input | 1 | low-power stop in effect |
| sys_rst_out | output | 1 | system reset request |
| limp | output | 1 | running without reference |
| eclk | output | 1 | divided E-bus clock |
| int_clk_sel | output | 1 | internal clock source, 1 = VCO, 0 = crystal |
| vco_enable | output | 1 | VCO run enable |
| clkout_en | output | 1 | output clock enable |
| freq_w | output | 1 | VCO multiplier select |
| freq_x | output | 1 | post-loop divide-by-two select |
| freq_y | output | 6 | feedback loop modulus |

## Verification
Every output of the unit is registered, so each result appears exactly one edge after the inputs that cause it are sampled. Register fields, the frequency outputs and the lock/limp/reset flags all follow this rule, and so does read data, which shows the register as it stood at the read edge. The relock wait reads as busy for RELOCK_CYCLES reads after the loading write. The bench changes inputs on the falling edge and advances a behavioural model on each rising edge. It compares every output 2 ns after each rising edge, so each check sees exactly the one-edge latency the requirements state.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;
  localparam int REG_W = 16;
  localparam int MOD_W = 6;
  localparam logic [MOD_W-1:0] MOD_RESET = '1;

  typedef struct packed {
    logic             vmul;
    logic             pre2;
    logic [MOD_W-1:0] modulus;
    logic             erate;
    logic             loss_rst;
    logic             stop_src;
    logic             stop_out;
  } ctl_fields_t;
endpackage

// File: rtl/clk_ctl_regs.sv
module clk_ctl_regs
  import clk_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_super,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             st_limp,
  input  logic             st_lock,
  output ctl_fields_t      fields,
  output logic [REG_W-1:0] bus_rdata,
  output logic             loop_change,
  output logic             written_once
);
  logic wr_ok, rd_ok;
  assign wr_ok = bus_sel & bus_wr & bus_super;
  assign rd_ok = bus_sel & ~bus_wr & bus_super;
  assign loop_change = wr_ok &
    ((bus_wdata[15] != fields.vmul) || (bus_wdata[13:8] != fields.modulus));

  always_ff @(posedge clk) begin
    if (rst) begin
      fields       <= '{vmul: 1'b0, pre2: 1'b0, modulus: MOD_RESET,
                        erate: 1'b0, loss_rst: 1'b0, stop_src: 1'b0, stop_out: 1'b0};
      written_once <= 1'b0;
    end else if (wr_ok) begin
      fields.vmul     <= bus_wdata[15];
      fields.pre2     <= bus_wdata[14];
      fields.modulus  <= bus_wdata[13:8];
      fields.erate    <= bus_wdata[7];
      fields.loss_rst <= bus_wdata[2];
      fields.stop_src <= bus_wdata[1];
      fields.stop_out <= bus_wdata[0];
      written_once    <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (rd_ok)
      bus_rdata <= {fields.vmul, fields.pre2, fields.modulus, fields.erate,
                    2'b00, st_limp, st_lock, fields.loss_rst,
                    fields.stop_src, fields.stop_out};
    else
      bus_rdata <= '0;
  end

  // R4: a write without privilege leaves the fields untouched
  a_r4_user_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && !bus_super) |=> $stable(fields));
  // R4: a read without privilege returns zero
  a_r4_user_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && !bus_super) |=> (bus_rdata == '0));
  // R6: lock flag never reads 1 before the first write
  a_r6_lock_hidden: assert property (@(posedge clk) disable iff (rst)
    !written_once |-> !st_lock);
endmodule

// File: rtl/clk_ctl_lock.sv
module clk_ctl_lock #(
  parameter int RELOCK_CYCLES = 16,
  localparam int RW = $clog2(RELOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic loop_change,
  input  logic written_once,
  input  logic vco_locked,
  input  logic ref_ok,
  input  logic loss_rst,
  output logic st_lock,
  output logic st_limp,
  output logic sys_rst_out
);
  localparam logic [RW-1:0] RELOAD = RW'(RELOCK_CYCLES);
  logic [RW-1:0] wait_cnt;
  logic          booted;

  always_ff @(posedge clk) begin
    if (rst)
      wait_cnt <= '0;
    else if (loop_change)
      wait_cnt <= RELOAD;
    else if (wait_cnt != '0)
      wait_cnt <= wait_cnt - 1'b1;
  end

  assign st_lock = written_once & vco_locked & (wait_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      booted      <= 1'b0;
      sys_rst_out <= 1'b1;
      st_limp     <= 1'b0;
    end else begin
      booted      <= booted | vco_locked;
      sys_rst_out <= ~(booted | vco_locked) | (~ref_ok & loss_rst);
      st_limp     <= ~ref_ok & ~loss_rst;
    end
  end

  // R7: a loop-changing write always opens the relock wait
  a_r7_relock_opens: assert property (@(posedge clk) disable iff (rst)
    loop_change |=> !st_lock);
  // R9: limp only arises when loss action selects limp
  a_r9_limp_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(st_limp) |-> ($past(!loss_rst) && $past(!ref_ok)));
  // R10: loss with reset action forces reset
  a_r10_loss_reset: assert property (@(posedge clk) disable iff (rst)
    (!ref_ok && loss_rst) |=> sys_rst_out);
endmodule

// File: rtl/clk_ctl_ediv.sv
module clk_ctl_ediv #(
  parameter int ECLK_FAST_DIV = 8,
  parameter int ECLK_SLOW_DIV = 16,
  localparam int CW = $clog2(ECLK_SLOW_DIV / 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic slow,
  output logic eclk
);
  localparam logic [CW-1:0] FAST_LAST = CW'(ECLK_FAST_DIV / 2 - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(ECLK_SLOW_DIV / 2 - 1);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  assign last = slow ? SLOW_LAST : FAST_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      eclk <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      eclk <= ~eclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: each phase lasts at least two cycles
  a_r5_phase_min: assert property (@(posedge clk) disable iff (rst)
    $rose(eclk) |=> eclk);
endmodule

// File: rtl/clk_ctl_stop.sv
module clk_ctl_stop (
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic stop_src,
  input  logic stop_out,
  output logic int_clk_sel,
  output logic vco_enable,
  output logic clkout_en
);
  logic xtal_mode;
  assign xtal_mode = stop_req & ~stop_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_clk_sel <= 1'b1;
      vco_enable  <= 1'b1;
      clkout_en   <= 1'b1;
    end else begin
      int_clk_sel <= ~xtal_mode;
      vco_enable  <= ~xtal_mode;
      clkout_en   <= ~stop_req | stop_out;
    end
  end

  // R11: stopping onto the crystal shuts the VCO
  a_r11_vco_off: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !stop_src) |=> (!vco_enable && !int_clk_sel));
  // R12: no stop means output clock runs
  a_r12_run_clkout: assert property (@(posedge clk) disable iff (rst)
    !stop_req |=> clkout_en);
endmodule

// File: rtl/clk_ctl_unit.sv
module clk_ctl_unit
  import clk_ctl_pkg::*;
#(
  parameter int RELOCK_CYCLES = 16,
  parameter int ECLK_FAST_DIV = 8,
  parameter int ECLK_SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_super,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             vco_locked,
  input  logic             ref_ok,
  input  logic             stop_req,
  output logic             sys_rst_out,
  output logic             limp,
  output logic             eclk,
  output logic             int_clk_sel,
  output logic             vco_enable,
  output logic             clkout_en,
  output logic             freq_w,
  output logic             freq_x,
  output logic [MOD_W-1:0] freq_y
);
  ctl_fields_t f;
  logic loop_change, written_once, st_lock;

  clk_ctl_regs u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_super(bus_super), .bus_wdata(bus_wdata),
    .st_limp(limp), .st_lock(st_lock), .fields(f), .bus_rdata(bus_rdata),
    .loop_change(loop_change), .written_once(written_once)
  );

  clk_ctl_lock #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .loop_change(loop_change),
    .written_once(written_once), .vco_locked(vco_locked), .ref_ok(ref_ok),
    .loss_rst(f.loss_rst), .st_lock(st_lock), .st_limp(limp),
    .sys_rst_out(sys_rst_out)
  );

  clk_ctl_ediv #(.ECLK_FAST_DIV(ECLK_FAST_DIV), .ECLK_SLOW_DIV(ECLK_SLOW_DIV)) u_ediv (
    .clk(clk), .rst(rst), .slow(f.erate), .eclk(eclk)
  );

  clk_ctl_stop u_stop (
    .clk(clk), .rst(rst), .stop_req(stop_req), .stop_src(f.stop_src),
    .stop_out(f.stop_out), .int_clk_sel(int_clk_sel),
    .vco_enable(vco_enable), .clkout_en(clkout_en)
  );

  assign freq_w = f.vmul;
  assign freq_x = f.pre2;
  assign freq_y = f.modulus;

  // R8: reset never released while lock has not been seen since reset
  a_r8_boot_hold: assert property (@(posedge clk) disable iff (rst)
    ($fell(sys_rst_out) && !f.loss_rst) |-> ($past(vco_locked) || !$past(sys_rst_out)));
endmodule

// File: tb/sim_clk_ctl_unit.sv
`timescale 1ns/1ps
module sim_clk_ctl_unit;
  localparam int RELOCK = 16;
  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0, bus_super = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic vco_locked = 0, ref_ok = 1, stop_req = 0;
  logic sys_rst_out, limp, eclk, int_clk_sel, vco_enable, clkout_en, freq_w, freq_x;
  logic [5:0] freq_y;
  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  clk_ctl_unit #(.RELOCK_CYCLES(RELOCK)) u0 (.*);

  // behavioural reference
  bit m_w, m_x, m_ediv, m_rsten, m_stsim, m_stext, m_once, m_boot, m_rsto, m_limp, m_eclk;
  bit m_isel, m_ven, m_cen;
  int m_y, m_relock, m_ecnt;
  logic [15:0] m_rdata;

  always @(posedge clk) begin
    bit lk, wr, rd; int half;
    if (rst) begin
      m_w = 0; m_x = 0; m_y = 63; m_ediv = 0; m_rsten = 0; m_stsim = 0; m_stext = 0;
      m_once = 0; m_boot = 0; m_rsto = 1; m_limp = 0; m_eclk = 0; m_ecnt = 0;
      m_relock = 0; m_rdata = 0; m_isel = 1; m_ven = 1; m_cen = 1;
    end else begin
      wr = bus_sel && bus_wr && bus_super;
      rd = bus_sel && !bus_wr && bus_super;
      lk = m_once && vco_locked && m_relock == 0;
      m_rdata = rd ? {m_w, m_x, 6'(m_y), m_ediv, 2'b00, m_limp, lk, m_rsten, m_stsim, m_stext} : 16'h0;
      half = m_ediv ? 8 : 4;
      if (m_ecnt >= half - 1) begin m_ecnt = 0; m_eclk = !m_eclk; end else m_ecnt++;
      m_rsto = !(m_boot || vco_locked) || (!ref_ok && m_rsten);
      m_boot = m_boot || vco_locked;
      m_limp = !ref_ok && !m_rsten;
      m_isel = !(stop_req && !m_stsim);
      m_ven = m_isel;
      m_cen = !stop_req || m_stext;
      if (wr && (bus_wdata[15] != m_w || int'(bus_wdata[13:8]) != m_y)) m_relock = RELOCK;
      else if (m_relock > 0) m_relock--;
      if (wr) begin
        m_w = bus_wdata[15]; m_x = bus_wdata[14]; m_y = int'(bus_wdata[13:8]);
        m_ediv = bus_wdata[7]; m_rsten = bus_wdata[2]; m_stsim = bus_wdata[1];
        m_stext = bus_wdata[0]; m_once = 1;
      end
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (phase %s) t=%0t actual=%h expected=%h", req, phase, $time, act, exp);
    end
  endtask

  // compare every cycle, 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    cycles++;
    chk("R3", bus_rdata, m_rdata);
    chk("R5", 16'(eclk), 16'(m_eclk));
    chk("R8", 16'(sys_rst_out), 16'(m_rsto));
    chk("R9", 16'(limp), 16'(m_limp));
    chk("R11", {int_clk_sel, vco_enable}, {m_isel, m_ven});
    chk("R12", 16'(clkout_en), 16'(m_cen));
    chk("R13", {freq_w, freq_x, 8'h00, freq_y}, {m_w, m_x, 8'h00, 6'(m_y)});
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); bus_sel = 0; bus_wr = 0; bus_super = 0;
    end
  endtask
  task automatic acc(bit wr, bit sup, logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = wr; bus_super = sup; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0; bus_super = 0;
  endtask
  // read with an explicit expectation at the next edge
  task automatic rd_exp(string req, logic [15:0] exp);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_super = 1;
    @(posedge clk); #2; chk(req, bus_rdata, exp);
    @(negedge clk); bus_sel = 0;
  endtask

  initial begin
    // R1 / R8: reset state and boot hold
    repeat (3) @(negedge clk);
    rst = 0;
    idle(3);
    @(posedge clk); #2; chk("R8", 16'(sys_rst_out), 16'h1);
    @(negedge clk); vco_locked = 1;
    @(posedge clk); #2; chk("R8", 16'(sys_rst_out), 16'h0);
    phase = "R1";
    rd_exp("R1", 16'h3F00);       // lock flag still hidden (R6)
    phase = "R6";
    rd_exp("R6", 16'h3F00);
    // R4: no privilege
    phase = "R4";
    acc(1, 0, 16'hFFFF);
    rd_exp("R4", 16'h3F00);
    acc(0, 0, 16'h0);
    @(posedge clk); #2; chk("R4", bus_rdata, 16'h0);
    // R7: prescale-only change, no relock; lock now visible (R6)
    phase = "R7";
    acc(1, 1, 16'h7F00);
    rd_exp("R7", 16'h7F08);
    // loop modulus change opens relock wait
    acc(1, 1, 16'h7000);
    rd_exp("R7", 16'h7000);
    idle(RELOCK);
    rd_exp("R7", 16'h7008);
    acc(1, 1, 16'hF000);          // vco multiplier change
    rd_exp("R7", 16'hF000);
    idle(RELOCK);
    // R2: status bits ignored, reserved read 0
    phase = "R2";
    acc(1, 1, 16'h70FF);
    idle(RELOCK);
    rd_exp("R2", 16'h708F);
    // R5: slow E clock
    phase = "R5";
    acc(1, 1, 16'h7080);
    idle(40);
    acc(1, 1, 16'h7000);
    idle(24);
    // R9: limp
    phase = "R9";
    @(negedge clk); ref_ok = 0;
    idle(3);
    rd_exp("R9", 16'h7018);
    @(negedge clk); ref_ok = 1;
    idle(3);
    // R10: reset on loss
    phase = "R10";
    acc(1, 1, 16'h7004);
    @(negedge clk); ref_ok = 0;
    @(posedge clk); #2; chk("R10", {sys_rst_out, limp}, 2'b10);
    @(negedge clk); ref_ok = 1;
    idle(3);
    // R11 / R12: stop combinations
    phase = "R11";
    foreach (bit_dummy[i]) ;
    for (int m = 0; m < 4; m++) begin
      acc(1, 1, 16'(16'h7000 | m));
      @(negedge clk); stop_req = 1;
      @(posedge clk); #2;
      chk("R11", {int_clk_sel, vco_enable}, {m[1], m[1]});
      chk("R12", 16'(clkout_en), 16'(m[0]));
      @(negedge clk); stop_req = 0;
      idle(2);
    end
    // R6: lock lost
    phase = "R6";
    @(negedge clk); vco_locked = 0;
    rd_exp("R6", 16'h7003);
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
  bit bit_dummy[1];
endmodule